// File: doc/BRIEF.md
# Authenticated Configuration Update Gate

This block is fixed logic that sits next to a reprogrammable fabric and decides whether an incoming configuration update may be installed. Each device carries a public fingerprint, a secret key and the version number of the configuration it currently runs. All three are fixed at build time apart from the version, which only this block can advance. An update presents a proposed version and a claimed authentication tag when `start_i` is pulsed. The payload words then follow on a valid/ready stream that ends with a last flag.

The gate computes its own keyed tag over the fingerprint, the proposed version and the payload. It accepts the update only when that tag equals the claimed one and the proposed version is strictly newer than the stored one. This refuses forged updates and replays of older genuine ones. The result is one `done_o` pulse carrying either `accept_o` or `reject_o`. On accept, the stored version moves to the proposed value. The keyed tag function is a deliberately simple placeholder for a real MAC. The secret key has no path to any output.

Top module: `upd_auth_ctrl`

## Requirements
- R1: After reset, `done_o`, `accept_o` and `reject_o` are 0, `pl_ready_o` is 0 and `cur_ver_o` equals the INIT_VER parameter.
- R2: The expected tag is computed with s = KEY, then s = rotl32(s ^ w, 5) + KEY (mod 2^32) for each word w. The words are taken in this order: the fingerprint, then the proposed version zero-extended to 32 bits, then the payload words in stream order.
- R3: With a matching tag and a proposed version greater than `cur_ver_o`, the block raises `accept_o` with `done_o`. In that same cycle `cur_ver_o` shows the new version.
- R4: With a tag that differs from the computed one, the block raises `reject_o` with `done_o`, and `cur_ver_o` is unchanged.
- R5: A proposed version equal to or lower than `cur_ver_o` is rejected even when the tag matches. This includes a proposed version of all ones when all ones is already stored.
- R6: Each update yields exactly one `done_o` pulse, one cycle long. Exactly one of `accept_o`/`reject_o` is 1 in that cycle, and both are 0 whenever `done_o` is 0. `done_o` comes two cycles after the handshake of the last payload word.
- R7: A `start_i` that arrives while an update is in progress is ignored. The proposed version and tag captured at the accepted start decide the result.
- R8: `pl_ready_o` is 0 while idle and in the two cycles after an accepted start. It is 1 from the third cycle until the last word is taken.
- R9: `cur_ver_o` changes only in a cycle where `accept_o` is 1.
- R10: `fingerprint_o` always equals the DEV_FP parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an update (sampled when idle) |
| new_ver_i | input | VER_W | Proposed version, captured at start |
| claim_tag_i | input | 32 | Claimed tag, captured at start |
| pl_valid_i | input | 1 | Payload word valid |
| pl_data_i | input | 32 | Payload word |
| pl_last_i | input | 1 | Marks the final payload word |
| pl_ready_o | output | 1 | Payload word can be taken |
| done_o | output | 1 | One-cycle result strobe |
| accept_o | output | 1 | Update accepted (with done_o) |
| reject_o | output | 1 | Update refused (with done_o) |
| fingerprint_o | output | 32 | Public device fingerprint |
| cur_ver_o | output | VER_W | Version of the installed configuration |

## Verification
The hardest cases to reach are a correctly tagged update refused only because it is stale, and a second start landing in the middle of a running update. The bench drives both on purpose. It replays an already accepted update with its valid tag, and it sends a correctly tagged update at the top version value. While payload words are spaced by random idle gaps, it holds `start_i` high with a scrambled version and tag. The random phase then mixes valid and corrupted tags with versions just below, at and above the stored one.

// File: rtl/upd_pkg.sv
`timescale 1ns/1ps
package upd_pkg;
    localparam int WORD_W = 32;
    localparam int ROT    = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FP,
        S_VER,
        S_PAY,
        S_CMP
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_FP,
        SEL_VER,
        SEL_PAY
    } mac_sel_e;

    typedef struct packed {
        logic done;
        logic accept;
        logic reject;
    } verdict_t;

    // Placeholder keyed mixing step; NOT cryptographically strong.
    function automatic word_t mac_step(word_t s, word_t w, word_t k);
        word_t x;
        x = s ^ w;
        return ((x << ROT) | (x >> (WORD_W - ROT))) + k;
    endfunction
endpackage

// File: rtl/upd_mac_core.sv
`timescale 1ns/1ps
module upd_mac_core
    import upd_pkg::*;
#(
    parameter word_t KEY = 32'h0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  absorb_i,
    input  word_t word_i,
    output word_t tag_o
);
    word_t acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q <= KEY;
        end else if (absorb_i) begin
            acc_q <= mac_step(acc_q, word_i, KEY);
        end
    end

    assign tag_o = acc_q;
endmodule

// File: rtl/upd_seq.sv
`timescale 1ns/1ps
module upd_seq
    import upd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     pl_valid_i,
    input  logic     pl_last_i,
    output logic     cap_o,
    output logic     mac_clr_o,
    output logic     mac_absorb_o,
    output mac_sel_e mac_sel_o,
    output logic     pl_ready_o,
    output logic     judge_o
);
    seq_state_e st_q, st_d;

    always_comb begin
        st_d         = st_q;
        cap_o        = 1'b0;
        mac_clr_o    = 1'b0;
        mac_absorb_o = 1'b0;
        mac_sel_o    = SEL_PAY;
        pl_ready_o   = 1'b0;
        judge_o      = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start_i) begin
                    cap_o     = 1'b1;
                    mac_clr_o = 1'b1;
                    st_d      = S_FP;
                end
            end
            S_FP: begin
                mac_absorb_o = 1'b1;
                mac_sel_o    = SEL_FP;
                st_d         = S_VER;
            end
            S_VER: begin
                mac_absorb_o = 1'b1;
                mac_sel_o    = SEL_VER;
                st_d         = S_PAY;
            end
            S_PAY: begin
                pl_ready_o   = 1'b1;
                mac_absorb_o = pl_valid_i;
                if (pl_valid_i && pl_last_i) begin
                    st_d = S_CMP;
                end
            end
            S_CMP: begin
                judge_o = 1'b1;
                st_d    = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/upd_ver_reg.sv
`timescale 1ns/1ps
module upd_ver_reg #(
    parameter int              VER_W    = 16,
    parameter logic [VER_W-1:0] INIT_VER = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_i,
    input  logic [VER_W-1:0] ver_i,
    output logic [VER_W-1:0] ver_o
);
    logic [VER_W-1:0] ver_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ver_q <= INIT_VER;
        end else if (commit_i) begin
            ver_q <= ver_i;
        end
    end

    assign ver_o = ver_q;
endmodule

// File: rtl/upd_auth_ctrl.sv
`timescale 1ns/1ps
module upd_auth_ctrl
    import upd_pkg::*;
#(
    parameter int               VER_W    = 16,
    parameter word_t            DEV_FP   = 32'h00C0_FFEE,
    parameter word_t            DEV_KEY  = 32'h5A17_C3E9,
    parameter logic [VER_W-1:0] INIT_VER = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [VER_W-1:0]  new_ver_i,
    input  logic [WORD_W-1:0] claim_tag_i,
    input  logic              pl_valid_i,
    input  logic [WORD_W-1:0] pl_data_i,
    input  logic              pl_last_i,
    output logic              pl_ready_o,
    output logic              done_o,
    output logic              accept_o,
    output logic              reject_o,
    output logic [WORD_W-1:0] fingerprint_o,
    output logic [VER_W-1:0]  cur_ver_o
);
    localparam int PAD_W = WORD_W - VER_W;

    logic             cap, mac_clr, mac_absorb, judge, pass;
    mac_sel_e         mac_sel;
    logic [VER_W-1:0] ver_q, stored_ver;
    word_t            tag_q, mac_tag, mac_word, ver_word;
    verdict_t         verdict_q;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ver_word = {{PAD_W{1'b0}}, ver_q};
        end else begin : g_nopad
            assign ver_word = ver_q[WORD_W-1:0];
        end
    endgenerate

    upd_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .pl_valid_i   (pl_valid_i),
        .pl_last_i    (pl_last_i),
        .cap_o        (cap),
        .mac_clr_o    (mac_clr),
        .mac_absorb_o (mac_absorb),
        .mac_sel_o    (mac_sel),
        .pl_ready_o   (pl_ready_o),
        .judge_o      (judge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ver_q <= '0;
            tag_q <= '0;
        end else if (cap) begin
            ver_q <= new_ver_i;
            tag_q <= claim_tag_i;
        end
    end

    always_comb begin
        unique case (mac_sel)
            SEL_FP:  mac_word = DEV_FP;
            SEL_VER: mac_word = ver_word;
            default: mac_word = pl_data_i;
        endcase
    end

    upd_mac_core #(.KEY(DEV_KEY)) u_mac (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (mac_clr),
        .absorb_i (mac_absorb),
        .word_i   (mac_word),
        .tag_o    (mac_tag)
    );

    assign pass = (mac_tag == tag_q) && (ver_q > stored_ver);

    upd_ver_reg #(.VER_W(VER_W), .INIT_VER(INIT_VER)) u_ver (
        .clk      (clk),
        .rst      (rst),
        .commit_i (judge && pass),
        .ver_i    (ver_q),
        .ver_o    (stored_ver)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.done   <= judge;
            verdict_q.accept <= judge && pass;
            verdict_q.reject <= judge && !pass;
        end
    end

    assign done_o        = verdict_q.done;
    assign accept_o      = verdict_q.accept;
    assign reject_o      = verdict_q.reject;
    assign fingerprint_o = DEV_FP;
    assign cur_ver_o     = stored_ver;
endmodule

// File: rtl/upd_auth_chk.sv
`timescale 1ns/1ps
module upd_auth_chk #(
    parameter int VER_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             pl_ready_o,
    input logic             done_o,
    input logic             accept_o,
    input logic             reject_o,
    input logic [VER_W-1:0] cur_ver_o
);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_one_verdict_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (accept_o ^ reject_o));

    p_quiet_verdict_r6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> !(accept_o || reject_o));

    p_ver_on_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (cur_ver_o != $past(cur_ver_o)) |-> accept_o);

    p_fresh_only_r5: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> (cur_ver_o > $past(cur_ver_o)));

    p_ready_vs_done_r8: assert property (@(posedge clk) disable iff (rst)
        pl_ready_o |-> !done_o);
endmodule

bind upd_auth_ctrl upd_auth_chk #(.VER_W(VER_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pl_ready_o (pl_ready_o),
    .done_o     (done_o),
    .accept_o   (accept_o),
    .reject_o   (reject_o),
    .cur_ver_o  (cur_ver_o)
);

// File: tb/upd_auth_ctrl_tb.sv
`timescale 1ns/1ps
module upd_auth_ctrl_tb;
    localparam logic [31:0] KEY  = 32'h5A17_C3E9;
    localparam logic [31:0] FP   = 32'h00C0_FFEE;
    localparam logic [15:0] IVER = 16'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] new_ver_i = '0;
    logic [31:0] claim_tag_i = '0;
    logic        pl_valid_i = 1'b0;
    logic [31:0] pl_data_i = '0;
    logic        pl_last_i = 1'b0;
    logic        pl_ready_o, done_o, accept_o, reject_o;
    logic [31:0] fingerprint_o;
    logic [15:0] cur_ver_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_ver = IVER;

    always #5 clk = ~clk;

    upd_auth_ctrl #(.VER_W(16), .DEV_FP(FP), .DEV_KEY(KEY), .INIT_VER(IVER)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .new_ver_i(new_ver_i),
        .claim_tag_i(claim_tag_i), .pl_valid_i(pl_valid_i), .pl_data_i(pl_data_i),
        .pl_last_i(pl_last_i), .pl_ready_o(pl_ready_o), .done_o(done_o),
        .accept_o(accept_o), .reject_o(reject_o), .fingerprint_o(fingerprint_o),
        .cur_ver_o(cur_ver_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] step(logic [31:0] s, logic [31:0] w);
        logic [31:0] x;
        x = s ^ w;
        return {x[26:0], x[31:27]} + KEY;
    endfunction

    // R2 reference: fingerprint, zero-extended version, payload in order
    function automatic logic [31:0] ref_tag(logic [15:0] v, logic [31:0] w[8], int n);
        logic [31:0] s;
        s = KEY;
        s = step(s, FP);
        s = step(s, {16'h0, v});
        for (int i = 0; i < n; i++) s = step(s, w[i]);
        return s;
    endfunction

    task automatic run_upd(input logic [15:0] v, input logic [31:0] tg,
                           input logic [31:0] w[8], input int n, input bit poke,
                           input string req);
        bit acc, rej;
        int dcnt, dpos;
        bit exp_ok;
        exp_ok = (tg == ref_tag(v, w, n)) && (v > exp_ver);
        @(negedge clk);
        start_i = 1'b1; new_ver_i = v; claim_tag_i = tg;
        @(negedge clk);
        start_i = 1'b0; new_ver_i = ~v; claim_tag_i = ~tg;
        chk(pl_ready_o == 1'b0, "R8", "ready in first cycle after start", pl_ready_o, 0);
        @(negedge clk);
        chk(pl_ready_o == 1'b0, "R8", "ready in second cycle after start", pl_ready_o, 0);
        for (int i = 0; i < n; i++) begin
            int gap = (poke ? 1 : 0) + int'($urandom % 3);
            for (int g = 0; g < gap; g++) begin
                start_i = poke;
                @(negedge clk);
            end
            start_i = 1'b0;
            pl_valid_i = 1'b1; pl_data_i = w[i]; pl_last_i = (i == n - 1);
            while (!pl_ready_o) @(negedge clk);
            @(negedge clk);
            pl_valid_i = 1'b0; pl_last_i = 1'b0; pl_data_i = $urandom;
        end
        dcnt = 0; dpos = -1; acc = 0; rej = 0;
        for (int k = 0; k < 5; k++) begin
            if (done_o) begin
                dcnt++; dpos = k; acc = accept_o; rej = reject_o;
                chk(cur_ver_o == (exp_ok ? v : exp_ver), "R3", "version at done",
                    cur_ver_o, exp_ok ? v : exp_ver);
            end else begin
                chk(!accept_o && !reject_o, "R6", "verdict without done",
                    {accept_o, reject_o}, 0);
            end
            @(negedge clk);
        end
        chk(dcnt == 1, "R6", "done pulse count", dcnt, 1);
        chk(dpos == 1, "R6", "done latency after last", dpos, 1);
        chk(acc == exp_ok && rej == !exp_ok, req, "verdict accept/reject",
            {acc, rej}, {exp_ok, !exp_ok});
        if (exp_ok) exp_ver = v;
        chk(cur_ver_o == exp_ver, "R9", "stored version after update", cur_ver_o, exp_ver);
        chk(fingerprint_o == FP, "R10", "fingerprint", fingerprint_o, FP);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] w[8];
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!done_o && !accept_o && !reject_o, "R1", "verdict after reset",
            {done_o, accept_o, reject_o}, 0);
        chk(pl_ready_o == 1'b0, "R1", "ready after reset", pl_ready_o, 0);
        chk(cur_ver_o == IVER, "R1", "version after reset", cur_ver_o, IVER);
        chk(fingerprint_o == FP, "R10", "fingerprint after reset", fingerprint_o, FP);

        for (int i = 0; i < 8; i++) w[i] = 32'h1000_0000 * (i + 1) + i;
        // R3 good update, three words
        run_upd(16'd5, ref_tag(16'd5, w, 3), w, 3, 1'b0, "R3");
        // R5 replay of the same update
        run_upd(16'd5, ref_tag(16'd5, w, 3), w, 3, 1'b0, "R5");
        // R5 older version with correct tag
        run_upd(16'd3, ref_tag(16'd3, w, 3), w, 3, 1'b0, "R5");
        // R4 wrong tag
        run_upd(16'd6, ref_tag(16'd6, w, 3) ^ 32'h1, w, 3, 1'b0, "R4");
        // R2 word order matters: tag over swapped payload
        begin
            logic [31:0] sw[8];
            sw = w; sw[0] = w[1]; sw[1] = w[0];
            run_upd(16'd6, ref_tag(16'd6, sw, 3), w, 3, 1'b0, "R2");
        end
        // R2 single-word payload
        run_upd(16'd6, ref_tag(16'd6, w, 1), w, 1, 1'b0, "R2");
        // R7 start held during the payload phase is ignored
        run_upd(16'd9, ref_tag(16'd9, w, 4), w, 4, 1'b1, "R7");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int n = 1 + int'($urandom % 8);
            logic [15:0] v;
            logic [31:0] tg;
            for (int i = 0; i < 8; i++) w[i] = $urandom;
            v = exp_ver + 16'($urandom % 5) - 16'd2;
            tg = ref_tag(v, w, n);
            if (($urandom % 10) < 3) tg = tg ^ (32'h1 << ($urandom % 32));
            run_upd(v, tg, w, n, ($urandom % 4) == 0, "R2");
        end

        // R5 top of the version range
        for (int i = 0; i < 8; i++) w[i] = $urandom;
        run_upd(16'hFFFF, ref_tag(16'hFFFF, w, 2), w, 2, 1'b0, "R3");
        run_upd(16'hFFFF, ref_tag(16'hFFFF, w, 2), w, 2, 1'b0, "R5");
        run_upd(16'h0000, ref_tag(16'h0000, w, 2), w, 2, 1'b0, "R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule